// File: doc/BRIEF.md
# Paired-Bank SEC-DED Memory Controller

This block sits between a host and two narrow memory banks. Each bank is 36 bits wide: a 32-bit data field and a 4-bit spare field. Every access touches both banks in the same cycle, so together they hold one 64-bit word plus 8 spare bits. In correcting mode the 8 spare bits carry an extended Hamming (72,64) code. Reads fix any single flipped bit, including a flipped check bit, and flag any two flipped bits. When the correcting mode is switched off, each spare bit holds even parity for one byte of its bank's word, and reads report a mismatch for each byte.

The host issues requests and takes read responses over two valid/ready channels. A request is held while `req_valid` is high and `req_ready` is low. Only one request is in flight at a time, and a read may not be accepted while an earlier read response still waits for `rsp_ready`. A read response holds its data and flags stable until `rsp_ready` takes it. A request may be accepted in the same cycle that the previous response is taken. Writes produce no response. The mode is sampled when a request is accepted. The banks return read data with a `bank_rvalid` pulse. The checked result appears on the response channel one clock cycle after that pulse.

Top module: `pairbank_secded`

## Requirements
- R1: In correcting mode, a write drives the low bank's data field (bits 31:0) with word bits 31:0 and the high bank's data field with word bits 63:32. Check bits 3:0 go to the low bank's bits 35:32 and check bits 7:4 to the high bank's bits 35:32. Codeword positions run from 0 to 71. Positions 1, 2, 4, 8, 16, 32 and 64 hold check bits 0 to 6, position 0 holds check bit 7, and the data bits fill the remaining positions in ascending order. Check bit k (k from 0 to 6) is the XOR of the data bits whose position has bit k set. Check bit 7 gives the whole 72-bit word even parity.
- R2: For each accepted request, the read strobes of both banks (or the write strobes of both banks) are high together for exactly the one cycle after acceptance, and `bank_addr` carries the request address.
- R3: A correcting-mode read with no flipped bit returns the stored word with all flags low. `rsp_valid` rises in the cycle after `bank_rvalid`.
- R4: A correcting-mode read with exactly one flipped bit among the 72 stored bits returns the stored word with `rsp_corrected` high and `rsp_uncorr` low.
- R5: A correcting-mode read with two flipped bits raises `rsp_uncorr`, keeps `rsp_corrected` low and returns the data fields as read, without correction.
- R6: In parity mode, a write sets spare bit k of the low bank to the XOR of word byte k (k from 0 to 3), and spare bit k of the high bank to the XOR of word byte k+4.
- R7: In parity mode, a read returns the data fields unchanged with both correction flags low. `rsp_par_err` bit k is the XOR of returned byte k and its spare bit: bits 0 to 3 cover the low bank and bits 4 to 7 the high bank.
- R8: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and its data does not change.
- R9: `req_ready` is low while a request is in flight, and also while a response waits for `rsp_ready`. It is high in a cycle where a held response is being taken. The mode used for a read is the one sampled at acceptance.
- R10: After reset, `req_ready` is high, `rsp_valid` is low and all bank strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | 1 = correcting mode, 0 = byte parity mode |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write word |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 64 | Read word (corrected where possible) |
| rsp_corrected | output | 1 | A single-bit error was fixed |
| rsp_uncorr | output | 1 | A double-bit error was detected |
| rsp_par_err | output | 8 | Per-byte parity mismatch (parity mode) |
| bank_addr | output | ADDR_W | Address to both banks |
| bank_lo_wr | output | 1 | Low bank write strobe |
| bank_lo_rd | output | 1 | Low bank read strobe |
| bank_hi_wr | output | 1 | High bank write strobe |
| bank_hi_rd | output | 1 | High bank read strobe |
| bank_lo_wdata | output | 36 | Low bank write bits |
| bank_hi_wdata | output | 36 | High bank write bits |
| bank_rvalid | input | 1 | Both banks return read bits |
| bank_lo_rdata | input | 36 | Low bank read bits |
| bank_hi_rdata | input | 36 | High bank read bits |

## Verification
Two things can happen in the same clock cycle: a held read response is taken, and the next request is accepted. To provoke this, the bench holds `rsp_ready` low with a second read already pending, and checks that `req_ready` stays low. It then releases `rsp_ready` and checks that, in that one cycle, `rsp_valid` and `req_ready` are both high. Both responses are then judged against the scoreboard queue in order. The bench also changes the mode right after a read is accepted, which confirms that the result follows the mode sampled at acceptance.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int WORD_W  = 64;
  localparam int CHK_W   = 8;
  localparam int HAM_W   = 7;
  localparam int CW_W    = WORD_W + CHK_W;
  localparam int HALF_W  = WORD_W / 2;
  localparam int SPARE_W = CHK_W / 2;
  localparam int BANK_W  = HALF_W + SPARE_W;
  localparam int BYTES   = WORD_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_ACCESS, ST_WAIT} pbs_state_e;

  function automatic logic [CW_W-1:0] pbs_spread(input logic [WORD_W-1:0] d);
    logic [CW_W-1:0] cw;
    int j;
    cw = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[j];
        j++;
      end
    end
    return cw;
  endfunction

  function automatic logic [WORD_W-1:0] pbs_gather(input logic [CW_W-1:0] cw);
    logic [WORD_W-1:0] d;
    int j;
    d = '0;
    j = 0;
    for (int p = 1; p < CW_W; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[j] = cw[p];
        j++;
      end
    end
    return d;
  endfunction

  function automatic logic [HAM_W-1:0] pbs_hsyn(input logic [CW_W-1:0] cw);
    logic [HAM_W-1:0] s;
    s = '0;
    for (int k = 0; k < HAM_W; k++)
      for (int p = 1; p < CW_W; p++)
        if (((p >> k) & 1) == 1) s[k] = s[k] ^ cw[p];
    return s;
  endfunction
endpackage

// File: rtl/pbs_encoder.sv
module pbs_encoder
  import pbs_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic              ecc_mode,
  output logic [BANK_W-1:0] lo_bits,
  output logic [BANK_W-1:0] hi_bits
);
  logic [CHK_W-1:0]  chk;
  logic [BYTES-1:0]  bpar;
  logic [CW_W-1:0]   cw;
  logic [HAM_W-1:0]  ham;

  always_comb begin
    cw  = pbs_spread(word);
    ham = pbs_hsyn(cw);
    chk = {(^word) ^ (^ham), ham};
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_bpar
    assign bpar[b] = ^word[8*b +: 8];
  end

  logic [CHK_W-1:0] spare;
  assign spare   = ecc_mode ? chk : bpar;
  assign lo_bits = {spare[SPARE_W-1:0], word[HALF_W-1:0]};
  assign hi_bits = {spare[CHK_W-1:SPARE_W], word[WORD_W-1:HALF_W]};
endmodule

// File: rtl/pbs_decoder.sv
module pbs_decoder
  import pbs_pkg::*;
(
  input  logic [BANK_W-1:0] lo_bits,
  input  logic [BANK_W-1:0] hi_bits,
  input  logic              ecc_mode,
  output logic [WORD_W-1:0] word,
  output logic              corrected,
  output logic              uncorr,
  output logic [BYTES-1:0]  par_err
);
  logic [WORD_W-1:0] raw;
  logic [CHK_W-1:0]  spare;
  logic [CW_W-1:0]   cw;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic [BYTES-1:0]  bmis;

  assign raw   = {hi_bits[HALF_W-1:0], lo_bits[HALF_W-1:0]};
  assign spare = {hi_bits[BANK_W-1:HALF_W], lo_bits[BANK_W-1:HALF_W]};

  for (genvar b = 0; b < BYTES; b++) begin : g_bchk
    assign bmis[b] = (^raw[8*b +: 8]) ^ spare[b];
  end

  always_comb begin
    cw = pbs_spread(raw);
    cw[0] = spare[CHK_W-1];
    for (int k = 0; k < HAM_W; k++) cw[1 << k] = spare[k];
    syn = pbs_hsyn(cw);
    odd = ^cw;
    corrected = 1'b0;
    uncorr    = 1'b0;
    word      = raw;
    par_err   = '0;
    if (!ecc_mode) begin
      par_err = bmis;
    end else if (odd) begin
      if (32'(syn) < CW_W) begin
        corrected = 1'b1;
        for (int p = 1; p < CW_W; p++)
          if (syn == HAM_W'(p)) cw[p] = ~cw[p];
        word = pbs_gather(cw);
      end else begin
        uncorr = 1'b1;
      end
    end else if (syn != '0) begin
      uncorr = 1'b1;
    end
  end
endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_rdata,
  output logic              rsp_corrected,
  output logic              rsp_uncorr,
  output logic [BYTES-1:0]  rsp_par_err,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [WORD_W-1:0] cmd_wdata,
  output logic              cmd_ecc,
  output logic              wr_stb,
  output logic              rd_stb,
  input  logic              bank_rvalid,
  input  logic [WORD_W-1:0] dec_word,
  input  logic              dec_corr,
  input  logic              dec_uncorr,
  input  logic [BYTES-1:0]  dec_perr
);
  pbs_state_e state;
  logic       cmd_we;
  logic       take;

  assign req_ready = (state == ST_IDLE) && (!rsp_valid || rsp_ready);
  assign take      = req_valid && req_ready;
  assign wr_stb    = (state == ST_ACCESS) && cmd_we;
  assign rd_stb    = (state == ST_ACCESS) && !cmd_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cmd_we    <= 1'b0;
      cmd_addr  <= '0;
      cmd_wdata <= '0;
      cmd_ecc   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (take) begin
          state     <= ST_ACCESS;
          cmd_we    <= req_we;
          cmd_addr  <= req_addr;
          cmd_wdata <= req_wdata;
          cmd_ecc   <= ecc_en;
        end
        ST_ACCESS: state <= cmd_we ? ST_IDLE : ST_WAIT;
        ST_WAIT:   if (bank_rvalid) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      rsp_corrected <= 1'b0;
      rsp_uncorr    <= 1'b0;
      rsp_par_err   <= '0;
    end else if (state == ST_WAIT && bank_rvalid) begin
      rsp_valid     <= 1'b1;
      rsp_rdata     <= dec_word;
      rsp_corrected <= dec_corr;
      rsp_uncorr    <= dec_uncorr;
      rsp_par_err   <= dec_perr;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R8: a stalled response holds
  p_rsp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  // R9: no bank read while a response slot is occupied
  p_rd_slot_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !rsp_valid);
  // R3: result follows the bank return by one cycle
  p_rsp_after_bank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bank_rvalid |=> rsp_valid);
  // R5: the two correction flags never appear together
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_corrected && rsp_uncorr));
  // R7: parity mismatches only on a parity-mode response
  p_perr_mode_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_corrected || rsp_uncorr) |-> rsp_par_err == '0);
  // R2: a strobe cycle is always followed by leaving the access state
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb || rd_stb) |=> !(wr_stb || rd_stb));
endmodule

// File: rtl/pairbank_secded.sv
module pairbank_secded
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ecc_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_corrected,
  output logic              rsp_uncorr,
  output logic [7:0]        rsp_par_err,
  output logic [ADDR_W-1:0] bank_addr,
  output logic              bank_lo_wr,
  output logic              bank_lo_rd,
  output logic              bank_hi_wr,
  output logic              bank_hi_rd,
  output logic [35:0]       bank_lo_wdata,
  output logic [35:0]       bank_hi_wdata,
  input  logic              bank_rvalid,
  input  logic [35:0]       bank_lo_rdata,
  input  logic [35:0]       bank_hi_rdata
);
  logic [WORD_W-1:0] cmd_wdata, dec_word;
  logic              cmd_ecc, wr_stb, rd_stb, dec_corr, dec_uncorr;
  logic [BYTES-1:0]  dec_perr;

  pbs_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ecc_en(ecc_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .rsp_corrected(rsp_corrected), .rsp_uncorr(rsp_uncorr),
    .rsp_par_err(rsp_par_err),
    .cmd_addr(bank_addr), .cmd_wdata(cmd_wdata), .cmd_ecc(cmd_ecc),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .bank_rvalid(bank_rvalid),
    .dec_word(dec_word), .dec_corr(dec_corr), .dec_uncorr(dec_uncorr),
    .dec_perr(dec_perr)
  );

  pbs_encoder u_enc (
    .word(cmd_wdata), .ecc_mode(cmd_ecc),
    .lo_bits(bank_lo_wdata), .hi_bits(bank_hi_wdata)
  );

  pbs_decoder u_dec (
    .lo_bits(bank_lo_rdata), .hi_bits(bank_hi_rdata), .ecc_mode(cmd_ecc),
    .word(dec_word), .corrected(dec_corr), .uncorr(dec_uncorr),
    .par_err(dec_perr)
  );

  assign bank_lo_wr = wr_stb;
  assign bank_hi_wr = wr_stb;
  assign bank_lo_rd = rd_stb;
  assign bank_hi_rd = rd_stb;
endmodule

// File: tb/sim_pairbank_secded.sv
module sim_pairbank_secded;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ecc_en = 1'b1;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic rsp_corrected, rsp_uncorr;
  logic [7:0] rsp_par_err;
  logic [AW-1:0] bank_addr;
  logic bank_lo_wr, bank_lo_rd, bank_hi_wr, bank_hi_rd;
  logic [35:0] bank_lo_wdata, bank_hi_wdata;
  logic bank_rvalid = 1'b0;
  logic [35:0] bank_lo_rdata = '0, bank_hi_rdata = '0;

  always #5 clk = ~clk;

  pairbank_secded #(.ADDR_W(AW)) u0 (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  int bp_mode = 0;
  logic [35:0] inj_lo = '0, inj_hi = '0;
  logic [35:0] mem_lo [16];
  logic [35:0] mem_hi [16];
  logic [63:0] shadow [16];

  // bank model: one-cycle read return with injected flips
  always @(posedge clk) begin
    bank_rvalid <= bank_lo_rd;
    if (bank_lo_rd) begin
      bank_lo_rdata <= mem_lo[bank_addr] ^ inj_lo;
      bank_hi_rdata <= mem_hi[bank_addr] ^ inj_hi;
    end
    if (bank_lo_wr) mem_lo[bank_addr] <= bank_lo_wdata;
    if (bank_hi_wr) mem_hi[bank_addr] <= bank_hi_wdata;
  end

  int cyc = 0;
  initial forever begin
    @(posedge clk);
    cyc++;
    #2;
    case (bp_mode)
      0: rsp_ready = 1'b1;
      1: rsp_ready = (cyc % 3) != 0;
      default: rsp_ready = 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected check bits, built by walking data bits to their positions
  function automatic logic [7:0] ref_chk(input logic [63:0] d);
    logic [6:0] h = '0;
    int pos = 1;
    for (int j = 0; j < 64; j++) begin
      while ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < 7; k++) if (((pos >> k) & 1) == 1) h[k] ^= d[j];
      pos++;
    end
    return {(^d) ^ (^h), h};
  endfunction

  function automatic logic [7:0] ref_par(input logic [63:0] d);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = ^d[8*b +: 8];
    return r;
  endfunction

  // scoreboard: {perr, uncorr, corr, data}
  logic [73:0] exp_q[$];
  string tag_q[$];

  logic [63:0] hold_data;
  bit stalled = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled)  // R8
        check(rsp_valid && rsp_rdata == hold_data, "R8",
              {15'd0, rsp_valid, rsp_rdata}, {15'd0, 1'b1, hold_data});
      stalled   = rsp_valid && !rsp_ready;
      hold_data = rsp_rdata;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R3 unexpected response", {6'd0, rsp_par_err, rsp_uncorr, rsp_corrected, rsp_rdata}, '0);
        end else begin
          logic [73:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check({rsp_par_err, rsp_uncorr, rsp_corrected, rsp_rdata} == e, t,
                {6'd0, rsp_par_err, rsp_uncorr, rsp_corrected, rsp_rdata}, {6'd0, e});
        end
      end
    end
  end

  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [63:0] d, input bit flip_mode);
    bit acc;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      acc = req_ready;
      @(posedge clk);
      if (acc) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
    if (flip_mode) ecc_en = ~ecc_en;
    // R2: both banks strobed together, right after acceptance
    check((we ? (bank_lo_wr && bank_hi_wr) : (bank_lo_rd && bank_hi_rd)) && !(bank_lo_wr && bank_lo_rd)
          && bank_addr == a, "R2",
          {74'd0, bank_lo_wr, bank_hi_wr, bank_lo_rd, bank_hi_rd, 2'd0}, {74'd0, we, we, !we, !we, 2'd0});
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    logic [7:0] sp;
    bit mode;
    mode = ecc_en;
    @(negedge clk);
    issue(1'b1, a, d, 0);
    shadow[a] = d;
    sp = mode ? ref_chk(d) : ref_par(d);
    if (mode)
      check(bank_lo_wdata == {sp[3:0], d[31:0]} && bank_hi_wdata == {sp[7:4], d[63:32]}, "R1",
            {8'd0, bank_hi_wdata, bank_lo_wdata}, {8'd0, sp[7:4], d[63:32], sp[3:0], d[31:0]});
    else
      check(bank_lo_wdata == {sp[3:0], d[31:0]} && bank_hi_wdata == {sp[7:4], d[63:32]}, "R6",
            {8'd0, bank_hi_wdata, bank_lo_wdata}, {8'd0, sp[7:4], d[63:32], sp[3:0], d[31:0]});
  endtask

  // read; exp built by caller; waits for the response to become valid
  task automatic rd(input logic [AW-1:0] a, input logic [73:0] e, input string t, input bit flip_mode);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    issue(1'b0, a, '0, flip_mode);
    @(negedge clk);
    @(negedge clk);
    check(rsp_valid, "R3 latency", {79'd0, rsp_valid}, 80'd1);
  endtask

  function automatic logic [73:0] exp_parity(input logic [AW-1:0] a);
    logic [63:0] d;
    logic [7:0] sp, pe;
    d  = {mem_hi[a][31:0] ^ inj_hi[31:0], mem_lo[a][31:0] ^ inj_lo[31:0]};
    sp = {mem_hi[a][35:32] ^ inj_hi[35:32], mem_lo[a][35:32] ^ inj_lo[35:32]};
    pe = ref_par(d) ^ sp;
    return {pe, 1'b0, 1'b0, d};
  endfunction

  initial begin
    #1_500_000;
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R10
    check(req_ready && !rsp_valid, "R10", {78'd0, req_ready, rsp_valid}, {78'd0, 2'b10});
    check(!(bank_lo_wr || bank_hi_wr || bank_lo_rd || bank_hi_rd), "R10",
          {76'd0, bank_lo_wr, bank_hi_wr, bank_lo_rd, bank_hi_rd}, '0);

    // correcting mode writes and clean reads
    ecc_en = 1'b1;
    wr(0, 64'h0123_4567_89AB_CDEF);
    wr(1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(2, 64'h0);
    wr(3, 64'h8000_0001_5A5A_A5A5);
    for (int a = 0; a < 4; a++) rd(AW'(a), {8'd0, 2'b00, shadow[a]}, "R3", 0);

    // every single flip, data and check bits
    for (int b = 0; b < 72; b++) begin
      inj_lo = (b < 36) ? (36'd1 << b) : '0;
      inj_hi = (b >= 36) ? (36'd1 << (b - 36)) : '0;
      rd(3, {8'd0, 2'b01, shadow[3]}, "R4", 0);
    end

    // double flips: raw data returned
    inj_lo = 36'h0_0000_0011; inj_hi = '0;
    rd(0, {8'd0, 2'b10, shadow[0] ^ 64'h11}, "R5", 0);
    inj_lo = 36'h0_0000_0100; inj_hi = 36'h0_0001_0000;
    rd(1, {8'd0, 2'b10, shadow[1] ^ {32'h0001_0000, 32'h0000_0100}}, "R5", 0);
    inj_lo = 36'h4_0000_0000; inj_hi = 36'h0_8000_0000;
    rd(2, {8'd0, 2'b10, shadow[2] ^ {32'h8000_0000, 32'h0}}, "R5", 0);
    inj_lo = '0; inj_hi = '0;

    // parity mode
    ecc_en = 1'b0;
    wr(8, 64'hDEAD_BEEF_0F1E_2D3C);
    wr(9, 64'h0000_00FF_0100_0003);
    rd(8, exp_parity(8), "R7 clean", 0);
    inj_lo = 36'h0_0000_0200; rd(8, exp_parity(8), "R7 byte1", 0);
    inj_lo = '0; inj_hi = 36'h4_0000_0000; rd(9, exp_parity(9), "R7 spare6", 0);
    inj_hi = 36'h0_0000_0300; rd(9, exp_parity(9), "R7 even pair", 0);
    inj_hi = '0;

    // R9: mode sampled at acceptance (flips to correcting right after)
    inj_lo = 36'h0_0000_0001;
    rd(8, exp_parity(8), "R9 mode latch", 1);
    check(ecc_en == 1'b1, "R9 mode flipped", {79'd0, ecc_en}, 80'd1);
    inj_lo = '0;

    // R8: back-pressure burst
    bp_mode = 1;
    for (int a = 0; a < 4; a++) rd(AW'(a), {8'd0, 2'b00, shadow[a]}, "R8 burst", 0);
    bp_mode = 2;
    rd(0, {8'd0, 2'b00, shadow[0]}, "R9 held A", 0);
    exp_q.push_back({8'd0, 2'b00, shadow[1]});
    tag_q.push_back("R9 B");
    req_valid = 1'b1; req_we = 1'b0; req_addr = 1;
    @(negedge clk);
    check(!req_ready && rsp_valid, "R9 blocked", {78'd0, req_ready, rsp_valid}, {78'd0, 2'b01});
    bp_mode = 0;
    @(negedge clk);
    check(req_ready && rsp_valid, "R9 same cycle", {78'd0, req_ready, rsp_valid}, {78'd0, 2'b11});
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(bank_lo_rd && bank_hi_rd, "R9 B issued", {78'd0, bank_lo_rd, bank_hi_rd}, {78'd0, 2'b11});
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 drained", 80'(exp_q.size()), '0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule